// File: doc/BRIEF.md
# Register-Shifted Move Decode and Execute Unit

This unit takes one instruction word and carries out a move whose source operand is shifted by an amount read from a second register. It accepts three encodings of the same operation: a fixed-width 32-bit form, a compact 16-bit form and a wide 32-bit compact form. A two-bit select input tells the unit which form the word should be read as. From the word it extracts the destination, source and shift-amount register indices, the shift kind and the flag-setting control. The source and shift-amount indices are returned combinationally, so that an outside register file can supply the two operands in the same cycle.

The unit shifts the source value by the low byte of the shift-amount register and produces a carry out. It then reports the result, a write enable and the next N, Z, C, V flags. Condition evaluation happens outside the block and arrives as a single pass flag. All outputs are registered and appear one cycle after a valid strobe. A word that does not belong to this operation raises a not-this-instruction output, and nothing is written.

Top module: `rsmove_unit`

## Requirements
- R1: With `enc_sel_i`=0 (fixed form) the word matches when bits [27:23]=00011, [22:21]=01, bit 7=0, bit 4=1 and the condition field [31:28] is not 1111. S is bit 20, destination is [15:12], shift-amount register is [11:8], shift kind is [6:5] and source is [3:0]. Bits [19:16] are not examined.
- R2: With `enc_sel_i`=1 (compact form, low 16 bits) the word matches when [15:10]=010000 and op [9:6] is one of 0010, 0011, 0100 or 0111. The shift kind is {op[2],op[0]}, the shift-amount register is {0,[5:3]}, and both source and destination are {0,[2:0]}.
- R3: With `enc_sel_i`=2 (wide form) the word matches when [31:23]=111110100, [15:12]=1111 and [7:4]=0000. The shift kind is [22:21], S is [20], source is [19:16], destination is [11:8] and the shift-amount register is [3:0].
- R4: A word that does not match, or `enc_sel_i`=3, gives `nomatch_o`=1 with `wr_en_o`=0, `unpred_o`=0 and `flags_o` equal to the incoming flags.
- R5: Shift kind 00 is logical left, 01 is logical right, 10 is arithmetic right and 11 is rotate right. The amount is the unsigned value of shift-register bits [7:0], and bits [31:8] have no effect.
- R6: An amount of zero returns the source unchanged, and the carry equals the incoming C.
- R7: For logical left or right by exactly 32, the result is 0 and the carry is bit 0 (left) or bit 31 (right). Above 32, both the result and the carry are 0. Arithmetic right by 32 or more sets every bit to the sign, and the carry equals the sign.
- R8: Rotate right uses the amount modulo 32. A nonzero multiple of 32 leaves the value unchanged, and the carry equals result bit 31.
- R9: When flag setting applies, N is result bit 31, Z is 1 exactly when the result is zero, C is the shifter carry and V keeps its incoming value. Without flag setting, `flags_o` equals the incoming flags. Flags are ordered {N,Z,C,V} from bit 3 down to bit 0.
- R10: In the compact form, flags are set exactly when `in_it_i`=0. In the two 32-bit forms, S alone decides.
- R11: When `cond_pass_i`=0, `wr_en_o`=0 and `flags_o` equals the incoming flags.
- R12: In the two 32-bit forms, a destination, source or shift-amount index of 15 sets `unpred_o`. The compact form never sets it.
- R13: Outputs update on the clock edge that samples `valid_i`=1, and `out_valid_o` is high for exactly that following cycle. When no strobe is sampled, `wr_en_o` and `nomatch_o` are 0. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word (compact form in bits [15:0]) |
| enc_sel_i | input | 2 | 0 fixed form, 1 compact form, 2 wide form, 3 none |
| in_it_i | input | 1 | Instruction sits inside a conditional block |
| cond_pass_i | input | 1 | Condition evaluated as passing |
| rm_data_i | input | 32 | Value of the source register |
| rs_data_i | input | 32 | Value of the shift-amount register |
| flags_i | input | 4 | Current {N,Z,C,V} |
| rm_idx_o | output | 4 | Decoded source index (combinational) |
| rs_idx_o | output | 4 | Decoded shift-amount index (combinational) |
| out_valid_o | output | 1 | Registered outputs are fresh |
| wr_en_o | output | 1 | Write result to destination |
| rd_idx_o | output | 4 | Destination index |
| result_o | output | 32 | Shifted value |
| flags_o | output | 4 | Next {N,Z,C,V} |
| unpred_o | output | 1 | Index 15 used in a 32-bit form |
| nomatch_o | output | 1 | Word is not this operation |

## Verification
The hardest cases to reach are the carry corners at amounts 0, 32, above 32 and multiples of 32 for rotate. Reaching them also needs shift-register values whose upper 24 bits are set while the low byte stays small or zero. The bench sweeps every form, every shift kind and an amount list covering 0 through 33 plus 63, 64, 96, 255, 0x101 and 0xFFFFFF00. It repeats the sweep over operand patterns that put different bits at the carry positions. Its reference shifter moves the value one bit per step, so the boundary results come out of plain repetition and not from a case split.

// File: rtl/rsmove_unit.sv
module rsmove_unit #(
  parameter int XLEN  = 32,
  parameter int AMT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [1:0]      enc_sel_i,
  input  logic            in_it_i,
  input  logic            cond_pass_i,
  input  logic [XLEN-1:0] rm_data_i,
  input  logic [XLEN-1:0] rs_data_i,
  input  logic [3:0]      flags_i,
  output logic [3:0]      rm_idx_o,
  output logic [3:0]      rs_idx_o,
  output logic            out_valid_o,
  output logic            wr_en_o,
  output logic [3:0]      rd_idx_o,
  output logic [XLEN-1:0] result_o,
  output logic [3:0]      flags_o,
  output logic            unpred_o,
  output logic            nomatch_o
);
  localparam int SH_W = $clog2(XLEN);

  logic       match, setfl, unpred;
  logic [1:0] kind;
  logic [3:0] rd, rm, rs;
  logic [3:0] op;

  assign op = insn_i[9:6];

  always_comb begin
    match  = 1'b0;
    setfl  = 1'b0;
    unpred = 1'b0;
    kind   = 2'b00;
    rd     = 4'd0;
    rm     = 4'd0;
    rs     = 4'd0;
    case (enc_sel_i)
      2'd0: begin
        match = (insn_i[31:28] != 4'hF) && (insn_i[27:23] == 5'b00011) &&
                (insn_i[22:21] == 2'b01) && !insn_i[7] && insn_i[4];
        setfl = insn_i[20];
        rd    = insn_i[15:12];
        rs    = insn_i[11:8];
        kind  = insn_i[6:5];
        rm    = insn_i[3:0];
      end
      2'd1: begin
        match = (insn_i[15:10] == 6'b010000) &&
                (op == 4'b0010 || op == 4'b0011 || op == 4'b0100 || op == 4'b0111);
        setfl = !in_it_i;
        kind  = {op[2], op[0]};
        rs    = {1'b0, insn_i[5:3]};
        rd    = {1'b0, insn_i[2:0]};
        rm    = {1'b0, insn_i[2:0]};
      end
      2'd2: begin
        match = (insn_i[31:23] == 9'b111110100) && (insn_i[15:12] == 4'hF) &&
                (insn_i[7:4] == 4'h0);
        kind  = insn_i[22:21];
        setfl = insn_i[20];
        rm    = insn_i[19:16];
        rd    = insn_i[11:8];
        rs    = insn_i[3:0];
      end
      default: match = 1'b0;
    endcase
    if (enc_sel_i != 2'd1)
      unpred = match && (rd == 4'hF || rm == 4'hF || rs == 4'hF);
  end

  assign rm_idx_o = rm;
  assign rs_idx_o = rs;

  logic [AMT_W-1:0] amt;
  logic [SH_W-1:0]  rot, lft_idx, rgt_idx;
  logic [XLEN-1:0]  sh_res;
  logic             sh_c;

  assign amt     = rs_data_i[AMT_W-1:0];
  assign rot     = amt[SH_W-1:0];
  assign lft_idx = SH_W'(XLEN - int'(amt));
  assign rgt_idx = SH_W'(int'(amt) - 1);

  always_comb begin
    sh_res = rm_data_i;
    sh_c   = flags_i[1];
    if (amt != '0) begin
      case (kind)
        2'b00: begin
          if (int'(amt) < XLEN) begin
            sh_res = rm_data_i << amt;
            sh_c   = rm_data_i[lft_idx];
          end else begin
            sh_res = '0;
            sh_c   = (int'(amt) == XLEN) ? rm_data_i[0] : 1'b0;
          end
        end
        2'b01: begin
          if (int'(amt) < XLEN) begin
            sh_res = rm_data_i >> amt;
            sh_c   = rm_data_i[rgt_idx];
          end else begin
            sh_res = '0;
            sh_c   = (int'(amt) == XLEN) ? rm_data_i[XLEN-1] : 1'b0;
          end
        end
        2'b10: begin
          if (int'(amt) < XLEN) begin
            sh_res = XLEN'($signed(rm_data_i) >>> amt);
            sh_c   = rm_data_i[rgt_idx];
          end else begin
            sh_res = {XLEN{rm_data_i[XLEN-1]}};
            sh_c   = rm_data_i[XLEN-1];
          end
        end
        default: begin
          if (rot == '0) begin
            sh_res = rm_data_i;
            sh_c   = rm_data_i[XLEN-1];
          end else begin
            sh_res = (rm_data_i >> rot) | (rm_data_i << (SH_W'(XLEN) - rot));
            sh_c   = rm_data_i[rot - SH_W'(1)];
          end
        end
      endcase
    end
  end

  logic [3:0] next_flags;
  always_comb begin
    next_flags = flags_i;
    if (match && cond_pass_i && setfl)
      next_flags = {sh_res[XLEN-1], (sh_res == '0), sh_c, flags_i[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      wr_en_o     <= 1'b0;
      rd_idx_o    <= '0;
      result_o    <= '0;
      flags_o     <= '0;
      unpred_o    <= 1'b0;
      nomatch_o   <= 1'b0;
    end else begin
      out_valid_o <= valid_i;
      wr_en_o     <= valid_i && match && cond_pass_i;
      nomatch_o   <= valid_i && !match;
      if (valid_i) begin
        rd_idx_o <= rd;
        result_o <= sh_res;
        flags_o  <= next_flags;
        unpred_o <= unpred;
      end
    end
  end
endmodule

// File: rtl/rsmove_chk.sv
module rsmove_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic [1:0]  enc_sel_i,
  input logic        cond_pass_i,
  input logic [3:0]  flags_i,
  input logic        out_valid_o,
  input logic        wr_en_o,
  input logic [3:0]  rd_idx_o,
  input logic [31:0] result_o,
  input logic [3:0]  flags_o,
  input logic        unpred_o,
  input logic        nomatch_o
);
  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o == $past(valid_i)); // R13
  AST_WE_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(valid_i && cond_pass_i)); // R11
  AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    nomatch_o |-> (!wr_en_o && !unpred_o)); // R4
  AST_V_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (flags_o[0] == $past(flags_i[0]))); // R9
  AST_Z_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && flags_o[2] != $past(flags_i[2])) |-> (flags_o[2] == (result_o == 32'd0))); // R9
  AST_FAIL_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !$past(cond_pass_i)) |-> (flags_o == $past(flags_i))); // R11
  AST_COMPACT_LOW_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && $past(enc_sel_i) == 2'd1 && !nomatch_o) |-> (!rd_idx_o[3] && !unpred_o)); // R12
endmodule

bind rsmove_unit rsmove_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .enc_sel_i(enc_sel_i),
  .cond_pass_i(cond_pass_i), .flags_i(flags_i), .out_valid_o(out_valid_o),
  .wr_en_o(wr_en_o), .rd_idx_o(rd_idx_o), .result_o(result_o),
  .flags_o(flags_o), .unpred_o(unpred_o), .nomatch_o(nomatch_o)
);

// File: tb/tb_rsmove_unit.sv
`timescale 1ns/1ps
module tb_rsmove_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [1:0]  enc_sel_i = 2'd3;
  logic        in_it_i = 1'b0;
  logic        cond_pass_i = 1'b0;
  logic [31:0] rm_data_i = '0;
  logic [31:0] rs_data_i = '0;
  logic [3:0]  flags_i = '0;
  logic [3:0]  rm_idx_o, rs_idx_o, rd_idx_o, flags_o;
  logic        out_valid_o, wr_en_o, unpred_o, nomatch_o;
  logic [31:0] result_o;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rsmove_unit dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .enc_sel_i(enc_sel_i), .in_it_i(in_it_i), .cond_pass_i(cond_pass_i),
    .rm_data_i(rm_data_i), .rs_data_i(rs_data_i), .flags_i(flags_i),
    .rm_idx_o(rm_idx_o), .rs_idx_o(rs_idx_o), .out_valid_o(out_valid_o),
    .wr_en_o(wr_en_o), .rd_idx_o(rd_idx_o), .result_o(result_o),
    .flags_o(flags_o), .unpred_o(unpred_o), .nomatch_o(nomatch_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [32:0] ref_shift(input logic [31:0] x, input logic [7:0] n,
                                            input logic [1:0] ty, input logic cin);
    logic [31:0] v;
    logic        c;
    v = x;
    c = cin;
    for (int i = 0; i < int'(n); i++) begin
      case (ty)
        2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  function automatic logic [3:0] op_of(input logic [1:0] ty);
    case (ty)
      2'd0: return 4'b0010;
      2'd1: return 4'b0011;
      2'd2: return 4'b0100;
      default: return 4'b0111;
    endcase
  endfunction

  task automatic run_op(input int form, input logic [1:0] ty, input logic s,
                        input logic [3:0] rd, input logic [3:0] rm, input logic [3:0] rs,
                        input logic [31:0] xv, input logic [31:0] sv, input logic [3:0] fi,
                        input logic it, input logic cp);
    logic [31:0] w;
    logic [3:0]  erd, erm, ers, ef;
    logic        setf, eun;
    logic [32:0] m;
    string       dreq, sreq, freq;
    case (form)
      0: begin w = {4'hE, 5'b00011, 2'b01, s, 4'h0, rd, rs, 1'b0, ty, 1'b1, rm};
               erd = rd; erm = rm; ers = rs; setf = s; dreq = "R1"; end
      1: begin w = {16'h0, 6'b010000, op_of(ty), rs[2:0], rd[2:0]};
               erd = {1'b0, rd[2:0]}; erm = erd; ers = {1'b0, rs[2:0]}; setf = !it; dreq = "R2"; end
      default: begin w = {9'b111110100, ty, s, rm, 4'hF, rd, 4'h0, rs};
               erd = rd; erm = rm; ers = rs; setf = s; dreq = "R3"; end
    endcase
    eun = (form != 1) && (erd == 4'hF || erm == 4'hF || ers == 4'hF);
    m = ref_shift(xv, sv[7:0], ty, fi[1]);
    ef = (cp && setf) ? {m[31], (m[31:0] == 32'd0), m[32], fi[0]} : fi;
    if (sv[7:0] == 8'd0) sreq = "R6";
    else if (sv[7:0] >= 8'd32) sreq = (ty == 2'd3) ? "R8" : "R7";
    else sreq = "R5";
    freq = !cp ? "R11" : (form == 1) ? "R10" : "R9";
    @(negedge clk);
    valid_i = 1'b1; insn_i = w; enc_sel_i = 2'(form); in_it_i = it;
    cond_pass_i = cp; rm_data_i = xv; rs_data_i = sv; flags_i = fi;
    #1;
    chk(rm_idx_o == erm, dreq, "source index", 32'(rm_idx_o), 32'(erm));
    chk(rs_idx_o == ers, dreq, "shift index", 32'(rs_idx_o), 32'(ers));
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    chk(out_valid_o == 1'b1, "R13", "out_valid", 32'(out_valid_o), 32'd1);
    chk(nomatch_o == 1'b0, dreq, "nomatch", 32'(nomatch_o), 32'd0);
    chk(wr_en_o == cp, "R11", "wr_en", 32'(wr_en_o), 32'(cp));
    chk(rd_idx_o == erd, dreq, "dest index", 32'(rd_idx_o), 32'(erd));
    chk(result_o == m[31:0], sreq, "result", result_o, m[31:0]);
    chk(flags_o == ef, freq, "flags", 32'(flags_o), 32'(ef));
    chk(unpred_o == eun, "R12", "unpred", 32'(unpred_o), 32'(eun));
  endtask

  task automatic run_bad(input int form, input logic [31:0] w, input logic [3:0] fi, input string what);
    @(negedge clk);
    valid_i = 1'b1; insn_i = w; enc_sel_i = 2'(form); cond_pass_i = 1'b1;
    in_it_i = 1'b0; flags_i = fi; rm_data_i = 32'h1; rs_data_i = 32'h1;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    chk(nomatch_o == 1'b1, "R4", {what, " nomatch"}, 32'(nomatch_o), 32'd1);
    chk(wr_en_o == 1'b0, "R4", {what, " wr_en"}, 32'(wr_en_o), 32'd0);
    chk(unpred_o == 1'b0, "R4", {what, " unpred"}, 32'(unpred_o), 32'd0);
    chk(flags_o == fi, "R4", {what, " flags"}, 32'(flags_o), 32'(fi));
  endtask

  function automatic logic [31:0] amt_of(input int k);
    case (k)
      34: return 32'd63;
      35: return 32'd64;
      36: return 32'd96;
      37: return 32'd255;
      38: return 32'h0000_0101;
      39: return 32'hFFFF_FF00;
      40: return 32'hABCD_EF21;
      default: return 32'(k);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_0F96;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({out_valid_o, wr_en_o, nomatch_o, unpred_o} == 4'd0, "R13", "reset controls",
        32'({out_valid_o, wr_en_o, nomatch_o, unpred_o}), 32'd0);
    chk(result_o == 32'd0 && flags_o == 4'd0 && rd_idx_o == 4'd0, "R13", "reset data",
        result_o, 32'd0);
    rst_n = 1'b1;

    for (int form = 0; form < 3; form++)
      for (int ty = 0; ty < 4; ty++)
        for (int k = 0; k < 41; k++)
          for (int p = 0; p < 3; p++)
            run_op(form, 2'(ty), 1'(p != 1), 4'((k + p) % 15), 4'((k * 3 + 1) % 15),
                   4'((k + 7) % 15), pats[p], amt_of(k),
                   (k % 2 == 0) ? 4'b0010 : 4'b1101, 1'(k % 3 == 0), 1'b1);

    // R11 condition fails
    run_op(0, 2'd0, 1'b1, 4'd2, 4'd3, 4'd4, 32'h0000_0001, 32'd31, 4'b0101, 1'b0, 1'b0);
    run_op(2, 2'd3, 1'b1, 4'd5, 4'd6, 4'd7, 32'h8000_0000, 32'd4, 4'b1010, 1'b0, 1'b0);
    // R10 compact inside and outside the conditional block, zero result
    run_op(1, 2'd1, 1'b0, 4'd1, 4'd1, 4'd2, 32'h0000_0001, 32'd1, 4'b1001, 1'b0, 1'b1);
    run_op(1, 2'd1, 1'b1, 4'd1, 4'd1, 4'd2, 32'h0000_0001, 32'd1, 4'b1001, 1'b1, 1'b1);
    // R12 index 15 in each position, both wide forms
    run_op(0, 2'd0, 1'b0, 4'hF, 4'd1, 4'd2, 32'h1, 32'd1, 4'd0, 1'b0, 1'b1);
    run_op(0, 2'd0, 1'b0, 4'd1, 4'hF, 4'd2, 32'h1, 32'd1, 4'd0, 1'b0, 1'b1);
    run_op(2, 2'd0, 1'b0, 4'd1, 4'd2, 4'hF, 32'h1, 32'd1, 4'd0, 1'b0, 1'b1);
    run_op(1, 2'd0, 1'b0, 4'hF, 4'hF, 4'hF, 32'h1, 32'd1, 4'd0, 1'b0, 1'b1);
    // R4 rejected words
    run_bad(0, {4'hF, 5'b00011, 2'b01, 1'b1, 4'h0, 4'd1, 4'd2, 1'b0, 2'b00, 1'b1, 4'd3}, 4'b0110, "R1 cond 1111");
    run_bad(0, {4'hE, 5'b00011, 2'b01, 1'b1, 4'h0, 4'd1, 4'd2, 1'b0, 2'b00, 1'b0, 4'd3}, 4'b0110, "R1 bit4 clear");
    run_bad(1, {16'h0, 6'b010000, 4'b0101, 3'd1, 3'd2}, 4'b1001, "R2 op 0101");
    run_bad(1, {16'h0, 6'b010000, 4'b1010, 3'd1, 3'd2}, 4'b1001, "R2 op 1010");
    run_bad(2, {9'b111110100, 2'b01, 1'b1, 4'd2, 4'hE, 4'd3, 4'h0, 4'd4}, 4'b0011, "R3 bits15:12");
    run_bad(3, {9'b111110100, 2'b01, 1'b1, 4'd2, 4'hF, 4'd3, 4'h0, 4'd4}, 4'b0011, "R4 select 3");
    // R1 bits [19:16] nonzero still match
    @(negedge clk);
    valid_i = 1'b1; enc_sel_i = 2'd0; cond_pass_i = 1'b1; flags_i = 4'd0;
    insn_i = {4'hE, 5'b00011, 2'b01, 1'b0, 4'hA, 4'd1, 4'd2, 1'b0, 2'b00, 1'b1, 4'd3};
    rm_data_i = 32'h3; rs_data_i = 32'd2;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    chk(nomatch_o == 1'b0 && result_o == 32'hC, "R1", "bits19:16 ignored", result_o, 32'hC);
    // R13 idle cycle: no strobe, no write
    @(posedge clk);
    @(negedge clk);
    chk(out_valid_o == 1'b0 && wr_en_o == 1'b0 && nomatch_o == 1'b0, "R13", "idle",
        32'({out_valid_o, wr_en_o, nomatch_o}), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule